// File: doc/BRIEF.md
# Register-Pair Signed Multiply/Divide Unit

This unit performs signed multiplication and division on a pair of 32-bit registers, where the first register of the pair must have an even number. The register file is outside the unit. The issuing stage supplies the first-register number, the current contents of the even and odd registers, and a second operand, then raises `start` for one cycle. The unit works through the operation one bit per cycle. When it finishes, it pulses `done` for one cycle. In that cycle it presents either the two words to write back to the pair or an exception flag.

In multiply, the odd register holds the 32-bit signed multiplicand. The multiplier is either the full second operand or the sign-extended low halfword of it. The 64-bit signed product is written across the pair, with the high word going to the even register.

In divide, the pair forms a 64-bit signed dividend, with the even register as the high word. The second operand is a 32-bit signed divisor. The remainder goes to the even register and the quotient goes to the odd register. The unit produces no condition code for either operation.

The controller is a five-state machine:
- `S_IDLE` waits for `start`.
- `S_CHECK` screens the divide operands.
- `S_ITER` runs 32 shift steps.
- `S_FIX` restores the signs and checks that the quotient fits in 32 bits.
- `S_REPORT` raises `done`.

The transitions are:
- IDLE→CHECK on a valid start.
- IDLE→REPORT on an odd register number.
- CHECK→REPORT on a divide fault found early.
- CHECK→ITER otherwise.
- ITER→FIX after the last step.
- FIX→REPORT always.
- REPORT→IDLE always.

Top module: `pairmd_unit`

## Requirements
- R1: An odd `r1_num` (bit 0 = 1) raises `spec_exc` together with `done` one cycle after start, with `wr_en` = 0 and no other operation; this takes precedence over any divide fault.
- R2: With `op` = 2'b00, the unit computes the signed 32-bit `pair_odd` times the signed 32-bit `operand2`; `even_out` carries product bits 63:32 and `odd_out` carries bits 31:0, with `wr_en` = 1.
- R3: With `op` = 2'b01, the multiplier is `operand2[15:0]` sign-extended, and `operand2[31:16]` has no effect on the result.
- R4: With `op[1]` = 1, the unit divides the signed 64-bit {`pair_even`,`pair_odd`} by the signed `operand2`. The quotient truncates toward zero and is returned on `odd_out`. The remainder takes the sign of the dividend and is returned on `even_out`.
- R5: A zero divisor raises `div_exc` with `wr_en` = 0, and `done` arrives two cycles after start.
- R6: A quotient outside the signed 32-bit range raises `div_exc` with `wr_en` = 0. The fault is reported two cycles after start when the dividend magnitude's high word is at least the divisor magnitude, and 35 cycles after start otherwise.
- R7: A completed multiply or divide raises `done` 35 cycles after start for exactly one cycle. `busy` is high from the cycle after start through the `done` cycle.
- R8: The `op` encoding is as follows: bit 1 selects divide, and bit 0 selects the halfword multiplier when bit 1 is 0. `op` = 2'b11 behaves as divide.
- R9: `start` is ignored while `busy` is high, so the running operation's result is unchanged.
- R10: After reset, `busy`, `done`, `wr_en`, `spec_exc`, `div_exc`, `even_out` and `odd_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | Operation select |
| r1_num | input | 4 | First-register number of the pair |
| pair_even | input | 32 | Even register contents |
| pair_odd | input | 32 | Odd register contents |
| operand2 | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Write the pair back (valid with done) |
| spec_exc | output | 1 | Odd register number fault (with done) |
| div_exc | output | 1 | Divide fault (with done) |
| even_out | output | 32 | Word for the even register |
| odd_out | output | 32 | Word for the odd register |

## Verification
The unit's results are due at three different times after the start edge:
- One cycle for a register-number fault.
- Two cycles for a zero divisor or an early-detected oversize quotient.
- 35 cycles for every multiply, every divide that runs to completion, and a late-detected oversize quotient.

For each operation, the bench computes which of these latencies applies from the operands. It then counts clock edges from the start edge, sampling on falling edges. It checks that `done` appears at exactly that count, and only at that point compares the flags and the two result words.

// File: rtl/pairmd_pkg.sv
package pairmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_ITER,
        S_FIX,
        S_REPORT
    } md_state_e;

endpackage

// File: rtl/pairmd_mulstep.sv
module pairmd_mulstep #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] p_in,
    input  logic [W-1:0]   addend,
    output logic [2*W-1:0] p_out
);
    logic [W:0] sum;

    always_comb begin
        sum   = {1'b0, p_in[2*W-1:W]} + (p_in[0] ? {1'b0, addend} : '0);
        p_out = {sum, p_in[W-1:1]};
    end
endmodule

// File: rtl/pairmd_divstep.sv
module pairmd_divstep #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] p_in,
    input  logic [W-1:0]   dvs,
    output logic [2*W-1:0] p_out
);
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         fits;
    logic [W-1:0] rem_n;

    always_comb begin
        trial = {p_in[2*W-1:W], p_in[W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = (trial >= {1'b0, dvs});
        rem_n = fits ? diff[W-1:0] : trial[W-1:0];
        p_out = {rem_n, p_in[W-2:0], fits};
    end
endmodule

// File: rtl/pairmd_unit.sv
module pairmd_unit
    import pairmd_pkg::*;
#(
    parameter int W  = 32,
    parameter int HW = 16,
    parameter int RN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [RN-1:0] r1_num,
    input  logic [W-1:0]  pair_even,
    input  logic [W-1:0]  pair_odd,
    input  logic [W-1:0]  operand2,
    output logic          busy,
    output logic          done,
    output logic          wr_en,
    output logic          spec_exc,
    output logic          div_exc,
    output logic [W-1:0]  even_out,
    output logic [W-1:0]  odd_out
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [W-1:0]  HALF = {1'b1, {(W-1){1'b0}}};

    md_state_e state, state_n;

    logic [CW-1:0] cnt;
    logic [DW-1:0] work;
    logic [W-1:0]  opmag;
    logic          is_div, neg_a, neg_b;
    logic          wr_q, spec_q, dexc_q;
    logic [W-1:0]  res_even, res_odd;

    logic [DW-1:0] mul_next, div_next;
    logic [W-1:0]  mplier;
    logic [DW-1:0] dvd;
    logic          early_fault;
    logic [DW-1:0] prod_signed;
    logic [W-1:0]  quot_mag, rem_mag;
    logic          quot_ovf;

    pairmd_mulstep #(.W(W)) u_mul (.p_in(work), .addend(opmag), .p_out(mul_next));
    pairmd_divstep #(.W(W)) u_div (.p_in(work), .dvs(opmag),   .p_out(div_next));

    always_comb begin
        mplier      = op[0] ? {{(W-HW){operand2[HW-1]}}, operand2[HW-1:0]} : operand2;
        dvd         = {pair_even, pair_odd};
        early_fault = (opmag == '0) || (work[DW-1:W] >= opmag);
        prod_signed = neg_a ? (~work + 1'b1) : work;
        quot_mag    = work[W-1:0];
        rem_mag     = work[DW-1:W];
        quot_ovf    = neg_b ? (quot_mag > HALF) : (quot_mag >= HALF);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (start) state_n = r1_num[0] ? S_REPORT : S_CHECK;
            S_CHECK:  state_n = (is_div && early_fault) ? S_REPORT : S_ITER;
            S_ITER:   if (cnt == LAST) state_n = S_FIX;
            S_FIX:    state_n = S_REPORT;
            S_REPORT: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            work     <= '0;
            opmag    <= '0;
            is_div   <= 1'b0;
            neg_a    <= 1'b0;
            neg_b    <= 1'b0;
            wr_q     <= 1'b0;
            spec_q   <= 1'b0;
            dexc_q   <= 1'b0;
            res_even <= '0;
            res_odd  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    wr_q   <= 1'b0;
                    dexc_q <= 1'b0;
                    spec_q <= r1_num[0];
                    cnt    <= '0;
                    is_div <= op[1];
                    if (op[1]) begin
                        work  <= dvd[DW-1] ? (~dvd + 1'b1) : dvd;
                        opmag <= operand2[W-1] ? (~operand2 + 1'b1) : operand2;
                        neg_a <= pair_even[W-1];
                        neg_b <= pair_even[W-1] ^ operand2[W-1];
                    end else begin
                        work  <= {{W{1'b0}}, pair_odd[W-1] ? (~pair_odd + 1'b1) : pair_odd};
                        opmag <= mplier[W-1] ? (~mplier + 1'b1) : mplier;
                        neg_a <= pair_odd[W-1] ^ mplier[W-1];
                        neg_b <= 1'b0;
                    end
                end
                S_CHECK: if (is_div && early_fault) dexc_q <= 1'b1;
                S_ITER: begin
                    work <= is_div ? div_next : mul_next;
                    cnt  <= cnt + 1'b1;
                end
                S_FIX: begin
                    if (!is_div) begin
                        res_even <= prod_signed[DW-1:W];
                        res_odd  <= prod_signed[W-1:0];
                        wr_q     <= 1'b1;
                    end else if (quot_ovf) begin
                        dexc_q <= 1'b1;
                    end else begin
                        res_even <= neg_a ? (~rem_mag + 1'b1) : rem_mag;
                        res_odd  <= neg_b ? (~quot_mag + 1'b1) : quot_mag;
                        wr_q     <= 1'b1;
                    end
                end
                S_REPORT: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_REPORT);
        wr_en    = done & wr_q;
        spec_exc = done & spec_q;
        div_exc  = done & dexc_q;
        even_out = res_even;
        odd_out  = res_odd;
    end
endmodule

// File: rtl/pairmd_chk.sv
module pairmd_chk #(
    parameter int W  = 32,
    parameter int RN = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op,
    input logic [RN-1:0] r1_num,
    input logic [W-1:0]  operand2,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic          spec_exc,
    input logic          div_exc
);
    a_r1_odd_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && r1_num[0]) |=> (done && spec_exc && !wr_en));

    a_r5_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !r1_num[0] && op[1] && operand2 == '0)
        |=> ##1 (done && div_exc && !wr_en));

    a_r6_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (spec_exc || div_exc)) |-> !wr_en);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r7_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r2_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);
endmodule

bind pairmd_unit pairmd_chk #(.W(W), .RN(RN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .r1_num(r1_num),
    .operand2(operand2), .busy(busy), .done(done), .wr_en(wr_en),
    .spec_exc(spec_exc), .div_exc(div_exc)
);

// File: tb/sim_pairmd_unit.sv
`timescale 1ns/1ps
module sim_pairmd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [3:0]  r1_num = '0;
    logic [31:0] pair_even = '0, pair_odd = '0, operand2 = '0;
    logic        busy, done, wr_en, spec_exc, div_exc;
    logic [31:0] even_out, odd_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pairmd_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .r1_num(r1_num),
        .pair_even(pair_even), .pair_odd(pair_odd), .operand2(operand2),
        .busy(busy), .done(done), .wr_en(wr_en), .spec_exc(spec_exc),
        .div_exc(div_exc), .even_out(even_out), .odd_out(odd_out)
    );

    // {op, r1, even, odd, operand2}
    localparam int NV = 16;
    localparam logic [101:0] VEC [NV] = '{
        {2'd0, 4'd2, 32'h0,        32'd7,        32'hFFFFFFFD},
        {2'd0, 4'd4, 32'h0,        32'h80000000, 32'h80000000},
        {2'd0, 4'd6, 32'h0,        32'hFFFFFF85, 32'h7FFFFFFF},
        {2'd1, 4'd8, 32'h0,        32'd1000,     32'hABCDFFFE},
        {2'd1, 4'd0, 32'h0,        32'hFFFFFFFB, 32'h00008000},
        {2'd2, 4'd2, 32'h0,        32'd100,      32'd7},
        {2'd2, 4'd2, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'd7},
        {2'd2, 4'd4, 32'h0,        32'd100,      32'hFFFFFFF9},
        {2'd2, 4'd6, 32'h1,        32'h0,        32'h10},
        {2'd2, 4'd8, 32'h0,        32'd55,       32'h0},
        {2'd2, 4'd10,32'h1,        32'h0,        32'h1},
        {2'd2, 4'd12,32'h0,        32'h80000000, 32'h1},
        {2'd2, 4'd14,32'hFFFFFFFF, 32'h80000000, 32'h1},
        {2'd3, 4'd2, 32'h0,        32'd9,        32'd2},
        {2'd0, 4'd3, 32'h0,        32'd7,        32'd3},
        {2'd2, 4'd5, 32'h0,        32'd9,        32'h0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [3:0] r,
                          input logic [31:0] e, input logic [31:0] od,
                          input logic [31:0] s);
        logic [63:0] exp_pair;
        logic [63:0] magd;
        logic [31:0] magv, s2e;
        longint      dvd, dvs, q, rm;
        bit          exp_spec, exp_dexc;
        int          exp_lat, lat;
        string       req;
        exp_pair = '0; exp_spec = 0; exp_dexc = 0; exp_lat = 35;
        if (r[0]) begin
            exp_spec = 1; exp_lat = 1; req = "R1";
        end else if (o[1]) begin
            req = (o == 2'b11) ? "R8" : "R4";
            dvd  = $signed({e, od});
            magd = dvd < 0 ? 64'(-dvd) : 64'(dvd);
            magv = s[31] ? (~s + 32'd1) : s;
            if (s == 0) begin
                exp_dexc = 1; exp_lat = 2; req = "R5";
            end else if (magd[63:32] >= magv) begin
                exp_dexc = 1; exp_lat = 2; req = "R6";
            end else begin
                dvs = longint'($signed(s));
                q   = dvd / dvs;
                rm  = dvd % dvs;
                if (q > 64'sd2147483647 || q < -64'sd2147483648) begin
                    exp_dexc = 1; req = "R6";
                end else exp_pair = {rm[31:0], q[31:0]};
            end
        end else begin
            req = o[0] ? "R3" : "R2";
            s2e = o[0] ? {{16{s[15]}}, s[15:0]} : s;
            exp_pair = 64'(longint'($signed(od)) * longint'($signed(s2e)));
        end

        @(negedge clk);
        op = o; r1_num = r; pair_even = e; pair_odd = od; operand2 = s; start = 1'b1;
        lat = 0;
        do begin
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 100);

        check(lat == exp_lat, "R7", {req, " latency"}, 64'(lat), 64'(exp_lat));
        check(spec_exc == exp_spec, req, "spec_exc", 64'(spec_exc), 64'(exp_spec));
        check(div_exc == exp_dexc, req, "div_exc", 64'(div_exc), 64'(exp_dexc));
        check(wr_en == !(exp_spec || exp_dexc), req, "wr_en", 64'(wr_en),
              64'(!(exp_spec || exp_dexc)));
        if (!exp_spec && !exp_dexc)
            check({even_out, odd_out} == exp_pair, req, "pair", {even_out, odd_out}, exp_pair);
        @(posedge clk); @(negedge clk);
        check(!done && !busy, "R7", "idle after done", {62'd0, busy, done}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check({busy, done, wr_en, spec_exc, div_exc} == 5'b0, "R10", "flags in reset",
              64'({busy, done, wr_en, spec_exc, div_exc}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({even_out, odd_out} == 64'd0 && !busy, "R10", "outputs after reset",
              {even_out, odd_out}, 64'd0);

        for (int i = 0; i < NV; i++)
            run_op(VEC[i][101:100], VEC[i][99:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);

        // R3: upper half of operand2 has no effect in halfword mode
        run_op(2'd1, 4'd2, 32'h0, 32'd1000, 32'h0000FFFE);

        // R9: start while busy is ignored
        @(negedge clk);
        op = 2'd0; r1_num = 4'd2; pair_odd = 32'd7; operand2 = 32'hFFFFFFFD; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op = 2'd2; r1_num = 4'd3; pair_odd = 32'd1; operand2 = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(!spec_exc && !div_exc && wr_en, "R9", "flags after ignored start",
              64'({spec_exc, div_exc, wr_en}), 64'd1);
        check({even_out, odd_out} == 64'hFFFFFFFF_FFFFFFEB, "R9", "result after ignored start",
              {even_out, odd_out}, 64'hFFFFFFFF_FFFFFFEB);
        @(negedge clk);

        // R10: reset in mid-operation returns to idle
        op = 2'd2; r1_num = 4'd2; pair_even = 32'd0; pair_odd = 32'd100; operand2 = 32'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && even_out == 0 && odd_out == 0, "R10", "mid-op reset",
              {even_out, odd_out}, 64'd0);
        rst_n = 1'b1;
        run_op(2'd2, 4'd2, 32'h0, 32'd100, 32'd7);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule